// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Read-Acknowledge

This block collects `N_IRQ` level-sensitive interrupt lines (64 by default) and delivers them to `N_CPU` processors (2 by default). Each line can be raised by its hardware input or by a software-trigger bit. It is suppressed by a per-line mask bit and steered by a per-line target bitmap. Each CPU has its own event-read port. A read on that port returns the lowest-numbered line that is pending, unmasked and routed to that CPU. In the same clock edge the read sets that line's mask bit. Handling therefore ends when software clears the mask bit again.

Configuration uses a 32-bit word bus with separate set and clear addresses for the mask and software-trigger bits, one target word per line, and an info word. Both the configuration bus and the event ports use valid/ready. Ready is tied high, so the block never applies back-pressure. A read answers exactly one cycle later with a response-valid pulse, and a response cannot be stalled. A write produces no response.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: A line is pending while its hardware input is high or its software-trigger bit is set (logical OR); a cleared software bit with a low input leaves it idle.
- R2: After reset every mask bit is 1, every software-trigger bit is 0 and every target word reads 1 (CPU 0 only).
- R3: An event read returns the lowest-numbered line that is pending, unmasked and has the reading CPU's bit set in its target word.
- R4: The edge that accepts an event read sets the mask bit of the reported line, so that line is not reported again until unmasked; when a mask-clear write hits the same bit on the same edge, the bit ends up set.
- R5: A line is reported only to CPUs whose bit is set in its target word; only the low `N_CPU` bits of a written target word are stored.
- R6: The event word has bits 31:24 = 0, bits 23:16 = 1 (hardware line) and bits 15:0 = line number; it is all zeros when nothing qualifies.
- R7: Mask-set (0x100), mask-clear (0x180), trigger-set (0x200) and trigger-clear (0x280) are word arrays: line n sits at bank + 4*(n>>5), bit n&31. Writing 1 acts on that bit, and writing 0 has no effect. A read of a set or clear address returns the current mask or trigger word.
- R8: The target word of line n is at 0x1000 + 4*n; bit c routes the line to CPU c.
- R9: Address 0x000 reads the number of implemented lines in bits 15:0 and ignores writes.
- R10: The bus accepts every cycle. A read returns data with `bus_rvalid` one cycle after acceptance. An undefined address reads zero.
- R11: When several CPUs read in the same cycle, lower-numbered CPUs choose first and a line taken by one CPU is excluded for the others, so no line is reported twice.
- R12: `ev_rvalid[c]` pulses exactly one cycle after an accepted event read by CPU c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl | input | N_IRQ | Level-sensitive interrupt inputs |
| bus_valid | input | 1 | Register access request |
| bus_ready | output | 1 | Always 1 |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| ev_valid | input | N_CPU | Per-CPU event read request |
| ev_ready | output | N_CPU | Always all ones |
| ev_rvalid | output | N_CPU | Per-CPU event response valid |
| ev_rdata | output | 32*N_CPU | Per-CPU event word, CPU c in bits 32c+31:32c |

## Verification
On every cycle the assertions check four things. The event word has its fixed format. A reported line was eligible for that CPU on the request edge and is masked afterwards. CPU 0 never skips a lower eligible line, and two CPUs never receive the same line together. Response pulses follow their requests by one cycle. The bench scenarios show the rest: the reset contents, set/clear semantics including zero bits, target storage width, routing to one CPU and not the other, the OR of hardware and software sources, and an acknowledge colliding with a mask-clear write.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int ADDR_W = 16;
  localparam logic [7:0]  EV_KIND_HW = 8'h01;
  localparam logic [15:0] OFS_INFO = 16'h0000;
  localparam logic [15:0] OFS_MSET = 16'h0100;
  localparam logic [15:0] OFS_MCLR = 16'h0180;
  localparam logic [15:0] OFS_SSET = 16'h0200;
  localparam logic [15:0] OFS_SCLR = 16'h0280;
  localparam logic [15:0] OFS_TGT  = 16'h1000;

  function automatic logic [31:0] pack_event(input logic [15:0] num);
    return {8'h00, EV_KIND_HW, num};
  endfunction
endpackage

// File: rtl/icu_first_set.sv
module icu_first_set #(
  parameter int N = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  assign found = |vec;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/icu_regs.sv
module icu_regs
  import icu_pkg::*;
#(
  parameter int N_IRQ = 64,
  parameter int N_CPU = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_valid,
  input  logic                           bus_we,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [31:0]                    bus_wdata,
  input  logic [N_IRQ-1:0]               ack_vec,
  output logic [N_IRQ-1:0]               mask_q,
  output logic [N_IRQ-1:0]               sw_q,
  output logic [N_IRQ-1:0][N_CPU-1:0]    tgt_q,
  output logic                           bus_rvalid,
  output logic [31:0]                    bus_rdata
);
  localparam int NW     = (N_IRQ + 31) / 32;
  localparam int WSEL_W = (NW > 1) ? $clog2(NW) : 1;
  localparam int NWP    = 1 << WSEL_W;
  localparam int PADW   = NWP * 32;
  localparam int TSEL_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  logic wr_en, rd_en;
  logic [8:0] blk;
  logic [4:0] bword;
  logic [9:0] tnum;
  logic [WSEL_W-1:0] wsel;
  logic [TSEL_W-1:0] tsel;
  logic word_ok, hit_info, hit_mset, hit_mclr, hit_sset, hit_sclr, hit_tgt;

  assign wr_en = bus_valid & bus_we;
  assign rd_en = bus_valid & ~bus_we;
  assign blk   = bus_addr[15:7];
  assign bword = bus_addr[6:2];
  assign tnum  = bus_addr[11:2];
  assign wsel  = bword[WSEL_W-1:0];
  assign tsel  = tnum[TSEL_W-1:0];

  assign word_ok  = (32'(bword) < NW);
  assign hit_info = (bus_addr[15:2] == OFS_INFO[15:2]);
  assign hit_mset = (blk == OFS_MSET[15:7]) && word_ok;
  assign hit_mclr = (blk == OFS_MCLR[15:7]) && word_ok;
  assign hit_sset = (blk == OFS_SSET[15:7]) && word_ok;
  assign hit_sclr = (blk == OFS_SCLR[15:7]) && word_ok;
  assign hit_tgt  = (bus_addr[15:12] == OFS_TGT[15:12]) && (32'(tnum) < N_IRQ);

  logic [PADW-1:0] mset_p, mclr_p, sset_p, sclr_p;
  for (genvar w = 0; w < NWP; w++) begin : g_word
    logic sel_w;
    assign sel_w = wr_en && (wsel == WSEL_W'(w));
    assign mset_p[w*32 +: 32] = (sel_w && hit_mset) ? bus_wdata : 32'h0;
    assign mclr_p[w*32 +: 32] = (sel_w && hit_mclr) ? bus_wdata : 32'h0;
    assign sset_p[w*32 +: 32] = (sel_w && hit_sset) ? bus_wdata : 32'h0;
    assign sclr_p[w*32 +: 32] = (sel_w && hit_sclr) ? bus_wdata : 32'h0;
  end

  logic [N_IRQ-1:0] mset, mclr, sset, sclr;
  assign mset = mset_p[N_IRQ-1:0];
  assign mclr = mclr_p[N_IRQ-1:0];
  assign sset = sset_p[N_IRQ-1:0];
  assign sclr = sclr_p[N_IRQ-1:0];

  // acknowledge is applied last so it wins over a same-edge clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      sw_q   <= '0;
    end else begin
      mask_q <= ((mask_q | mset) & ~mclr) | ack_vec;
      sw_q   <= (sw_q | sset) & ~sclr;
    end
  end

  for (genvar n = 0; n < N_IRQ; n++) begin : g_tgt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tgt_q[n] <= N_CPU'(1);
      else if (wr_en && hit_tgt && (tsel == TSEL_W'(n)))
        tgt_q[n] <= bus_wdata[N_CPU-1:0];
    end
  end

  logic [PADW-1:0] mask_p, sw_p;
  logic [31:0] rmux;
  assign mask_p = PADW'(mask_q);
  assign sw_p   = PADW'(sw_q);

  always_comb begin
    rmux = 32'h0;
    if (hit_info)
      rmux = 32'(N_IRQ);
    else if (hit_mset || hit_mclr)
      rmux = mask_p[wsel*32 +: 32];
    else if (hit_sset || hit_sclr)
      rmux = sw_p[wsel*32 +: 32];
    else if (hit_tgt)
      rmux = 32'(tgt_q[tsel]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= 32'h0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rmux;
    end
  end
endmodule

// File: rtl/icu_route_arb.sv
module icu_route_arb
  import icu_pkg::*;
#(
  parameter int N_IRQ = 64,
  parameter int N_CPU = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_IRQ-1:0]             avail,
  input  logic [N_IRQ-1:0][N_CPU-1:0]  tgt,
  input  logic [N_CPU-1:0]             ev_valid,
  output logic [N_IRQ-1:0]             ack_vec,
  output logic [N_CPU-1:0]             ev_rvalid,
  output logic [N_CPU*32-1:0]          ev_rdata
);
  localparam int IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  logic [N_CPU:0][N_IRQ-1:0]   pool;
  logic [N_CPU-1:0][N_IRQ-1:0] col, cand, pick;
  logic [N_CPU-1:0]            hit;
  logic [N_CPU-1:0][IW-1:0]    idx;
  logic [N_CPU-1:0][31:0]      data_q;

  assign pool[0] = avail;

  // CPU c chooses from what lower CPUs left behind
  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    for (genvar n = 0; n < N_IRQ; n++) begin : g_col
      assign col[c][n] = tgt[n][c];
    end
    assign cand[c] = pool[c] & col[c];
    icu_first_set #(.N(N_IRQ)) u_first (
      .vec  (cand[c]),
      .found(hit[c]),
      .idx  (idx[c])
    );
    assign pick[c]   = (ev_valid[c] && hit[c]) ? (N_IRQ'(1) << idx[c]) : '0;
    assign pool[c+1] = pool[c] & ~pick[c];
  end

  assign ack_vec  = pool[0] & ~pool[N_CPU];
  assign ev_rdata = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_rvalid <= '0;
      data_q    <= '0;
    end else begin
      ev_rvalid <= ev_valid;
      for (int c = 0; c < N_CPU; c++) begin
        if (ev_valid[c])
          data_q[c] <= hit[c] ? pack_event(16'(idx[c])) : 32'h0;
      end
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import icu_pkg::*;
#(
  parameter int N_IRQ = 64,
  parameter int N_CPU = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_IRQ-1:0]      irq_lvl,
  input  logic                  bus_valid,
  output logic                  bus_ready,
  input  logic                  bus_we,
  input  logic [15:0]           bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic                  bus_rvalid,
  output logic [31:0]           bus_rdata,
  input  logic [N_CPU-1:0]      ev_valid,
  output logic [N_CPU-1:0]      ev_ready,
  output logic [N_CPU-1:0]      ev_rvalid,
  output logic [N_CPU*32-1:0]   ev_rdata
);
  logic [N_IRQ-1:0]            mask_q, sw_q, ack_vec, avail;
  logic [N_IRQ-1:0][N_CPU-1:0] tgt_q;

  assign bus_ready = 1'b1;
  assign ev_ready  = '1;
  assign avail     = (irq_lvl | sw_q) & ~mask_q;

  icu_regs #(.N_IRQ(N_IRQ), .N_CPU(N_CPU)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ack_vec   (ack_vec),
    .mask_q    (mask_q),
    .sw_q      (sw_q),
    .tgt_q     (tgt_q),
    .bus_rvalid(bus_rvalid),
    .bus_rdata (bus_rdata)
  );

  icu_route_arb #(.N_IRQ(N_IRQ), .N_CPU(N_CPU)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .avail    (avail),
    .tgt      (tgt_q),
    .ev_valid (ev_valid),
    .ack_vec  (ack_vec),
    .ev_rvalid(ev_rvalid),
    .ev_rdata (ev_rdata)
  );
endmodule

// File: rtl/icu_checker.sv
module icu_checker #(
  parameter int N_IRQ = 64,
  parameter int N_CPU = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [N_IRQ-1:0]             irq_lvl,
  input logic [N_IRQ-1:0]             mask_q,
  input logic [N_IRQ-1:0]             sw_q,
  input logic [N_IRQ-1:0][N_CPU-1:0]  tgt_q,
  input logic [N_CPU-1:0]             ev_valid,
  input logic [N_CPU-1:0]             ev_rvalid,
  input logic [N_CPU*32-1:0]          ev_rdata,
  input logic                         bus_valid,
  input logic                         bus_we,
  input logic                         bus_rvalid
);
  logic [N_IRQ-1:0] live, col0, live_d, cand0_d;
  logic [N_CPU-1:0] ev_valid_d;
  logic             rd_d;
  logic [N_CPU-1:0][31:0] w;

  assign w = ev_rdata;
  assign live = (irq_lvl | sw_q) & ~mask_q;
  always_comb for (int n = 0; n < N_IRQ; n++) col0[n] = tgt_q[n][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_d <= '0; cand0_d <= '0; ev_valid_d <= '0; rd_d <= 1'b0;
    end else begin
      live_d <= live; cand0_d <= live & col0;
      ev_valid_d <= ev_valid; rd_d <= bus_valid & ~bus_we;
    end
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_c
    logic [15:0] num;
    assign num = w[c][15:0];

    a_r6_event_format: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rvalid[c] && w[c] != 0) |-> (w[c][31:16] == 16'h0001 && 32'(num) < N_IRQ));
    a_r4_ack_sets_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rvalid[c] && w[c] != 0) |-> mask_q[num]);
    a_r3_was_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rvalid[c] && w[c] != 0) |-> live_d[num]);
    a_r12_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rvalid[c] == ev_valid_d[c]);
    if (c == 0) begin : g_first
      a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rvalid[0] && w[0] != 0) |-> ((cand0_d & ((N_IRQ'(1) << num) - N_IRQ'(1))) == '0));
      a_r3_empty_means_none: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rvalid[0] && w[0] == 0) |-> (cand0_d == '0));
    end else begin : g_other
      a_r11_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rvalid[0] && ev_rvalid[c] && w[0] != 0 && w[c] != 0) |-> (w[0][15:0] != num));
    end
  end

  a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid == rd_d);
endmodule

bind lvl_irq_ctrl icu_checker #(.N_IRQ(N_IRQ), .N_CPU(N_CPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .mask_q(mask_q), .sw_q(sw_q),
  .tgt_q(tgt_q), .ev_valid(ev_valid), .ev_rvalid(ev_rvalid), .ev_rdata(ev_rdata),
  .bus_valid(bus_valid), .bus_we(bus_we), .bus_rvalid(bus_rvalid)
);

// File: tb/lvl_irq_ctrl_tb_top.sv
module lvl_irq_ctrl_tb_top;
  localparam int N  = 64;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_lvl = '0;
  logic b_valid = 0, b_we = 0;
  logic [15:0] b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic b_ready, b_rvalid;
  logic [31:0] b_rdata;
  logic [NC-1:0] ev_valid = '0, ev_ready, ev_rvalid;
  logic [NC*32-1:0] ev_rdata;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lvl_irq_ctrl #(.N_IRQ(N), .N_CPU(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl),
    .bus_valid(b_valid), .bus_ready(b_ready), .bus_we(b_we), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rvalid(b_rvalid), .bus_rdata(b_rdata),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_rvalid(ev_rvalid), .ev_rdata(ev_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_mask[N], m_sw[N], m_av[N], m_ack[N];
  int m_tgt[N];
  bit e_bv;
  logic [31:0] e_bd;
  bit e_evv[NC];
  logic [31:0] e_evd[NC];

  function automatic logic [31:0] m_read(input logic [15:0] a);
    int kind = a[15:7];
    int wd = a[6:2];
    logic [31:0] r = 0;
    if (a[15:2] == 0) return N;
    if (kind >= 2 && kind <= 5 && wd < N / 32) begin
      for (int k = 0; k < 32; k++)
        r[k] = (kind <= 3) ? m_mask[wd*32+k] : m_sw[wd*32+k];
      return r;
    end
    if (a[15:12] == 1 && a[11:2] < N) return m_tgt[a[11:2]];
    return 0;
  endfunction

  task automatic m_write(input logic [15:0] a, input logic [31:0] d);
    int kind = a[15:7];
    int wd = a[6:2];
    if (kind >= 2 && kind <= 5 && wd < N / 32) begin
      for (int k = 0; k < 32; k++) if (d[k]) begin
        case (kind)
          2: m_mask[wd*32+k] = 1;
          3: m_mask[wd*32+k] = 0;
          4: m_sw[wd*32+k] = 1;
          default: m_sw[wd*32+k] = 0;
        endcase
      end
    end else if (a[15:12] == 1 && a[11:2] < N) begin
      m_tgt[a[11:2]] = d & ((1 << NC) - 1);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_mask[i] = 1; m_sw[i] = 0; m_tgt[i] = 1; end
      e_bv = 0; e_bd = 0;
      for (int c = 0; c < NC; c++) begin e_evv[c] = 0; e_evd[c] = 0; end
    end else begin
      for (int i = 0; i < N; i++) begin
        m_av[i] = (irq_lvl[i] || m_sw[i]) && !m_mask[i];
        m_ack[i] = 0;
      end
      for (int c = 0; c < NC; c++) begin
        e_evv[c] = ev_valid[c];
        if (ev_valid[c]) begin
          e_evd[c] = 0;
          for (int i = 0; i < N; i++) begin
            if (m_av[i] && m_tgt[i][c]) begin
              e_evd[c] = 32'h0001_0000 | i;
              m_av[i] = 0; m_ack[i] = 1;
              break;
            end
          end
        end
      end
      e_bv = b_valid && !b_we;
      if (e_bv) e_bd = m_read(b_addr);
      if (b_valid && b_we) m_write(b_addr, b_wdata);
      for (int i = 0; i < N; i++) if (m_ack[i]) m_mask[i] = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 model bus_rvalid", 32'(b_rvalid), 32'(e_bv));
      if (e_bv) chk("R7 R8 R9 model bus_rdata", b_rdata, e_bd);
      for (int c = 0; c < NC; c++) begin
        chk("R12 model ev_rvalid", 32'(ev_rvalid[c]), 32'(e_evv[c]));
        if (e_evv[c]) chk("R3 R5 model ev_rdata", ev_rdata[c*32 +: 32], e_evd[c]);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); b_valid = 1; b_we = 1; b_addr = a; b_wdata = d;
    @(negedge clk); b_valid = 0; b_we = 0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); b_valid = 1; b_we = 0; b_addr = a;
    @(negedge clk); b_valid = 0;
    chk("R10 read response", 32'(b_rvalid), 32'd1);
    d = b_rdata;
  endtask

  task automatic ev_rd(input logic [NC-1:0] who, output logic [31:0] d0, output logic [31:0] d1);
    @(negedge clk); ev_valid = who;
    @(negedge clk); ev_valid = '0;
    chk("R12 event response", 32'(ev_rvalid), 32'(who));
    d0 = ev_rdata[31:0]; d1 = ev_rdata[63:32];
  endtask

  initial begin
    logic [31:0] d, d0, d1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // reset contents
    bus_rd(16'h0000, d); chk("R9 info count", d, 32'd64);
    bus_rd(16'h0100, d); chk("R2 mask word0 after reset", d, 32'hFFFF_FFFF);
    bus_rd(16'h0184, d); chk("R2 R7 mask word1 via clear addr", d, 32'hFFFF_FFFF);
    bus_rd(16'h0200, d); chk("R2 trigger word0 after reset", d, 32'h0);
    bus_rd(16'h1014, d); chk("R2 R8 target of line 5", d, 32'h1);
    bus_rd(16'h0040, d); chk("R10 undefined address", d, 32'h0);
    ev_rd(2'b11, d0, d1); chk("R6 empty cpu0", d0, 32'h0); chk("R6 empty cpu1", d1, 32'h0);
    // unmask 3 and 10, zero write has no effect
    bus_wr(16'h0180, 32'h0000_0408);
    bus_rd(16'h0100, d); chk("R7 mask after clear", d, 32'hFFFF_FBF7);
    bus_wr(16'h0180, 32'h0);
    bus_rd(16'h0100, d); chk("R7 zero write ignored", d, 32'hFFFF_FBF7);
    irq_lvl[10] = 1'b1;
    bus_wr(16'h0200, 32'h0000_0008);
    ev_rd(2'b01, d0, d1); chk("R1 R3 software line 3 first", d0, 32'h0001_0003);
    ev_rd(2'b01, d0, d1); chk("R1 R4 hardware line 10 next", d0, 32'h0001_000A);
    ev_rd(2'b01, d0, d1); chk("R4 both acknowledged", d0, 32'h0);
    bus_rd(16'h0100, d); chk("R4 masks set by reads", d, 32'hFFFF_FFFF);
    // software clear
    bus_wr(16'h0180, 32'h8);
    ev_rd(2'b01, d0, d1); chk("R1 trigger still set", d0, 32'h0001_0003);
    bus_wr(16'h0280, 32'h8);
    bus_wr(16'h0180, 32'h8);
    ev_rd(2'b01, d0, d1); chk("R1 cleared trigger idle", d0, 32'h0);
    bus_rd(16'h0200, d); chk("R7 trigger word0", d, 32'h0);
    // routing to cpu1
    bus_wr(16'h10A0, 32'h2);
    bus_rd(16'h10A0, d); chk("R8 target of line 40", d, 32'h2);
    bus_wr(16'h0184, 32'h0000_0100);
    irq_lvl[40] = 1'b1;
    ev_rd(2'b01, d0, d1); chk("R5 not routed to cpu0", d0, 32'h0);
    ev_rd(2'b10, d0, d1); chk("R5 routed to cpu1", d1, 32'h0001_0028);
    bus_wr(16'h10A0, 32'hFFFF_FFFE);
    bus_rd(16'h10A0, d); chk("R5 only low target bits kept", d, 32'h2);
    // simultaneous reads
    bus_wr(16'h1050, 32'h3);
    bus_wr(16'h1054, 32'h3);
    bus_wr(16'h0200, 32'h0030_0000);
    bus_wr(16'h0180, 32'h0030_0000);
    ev_rd(2'b11, d0, d1);
    chk("R11 cpu0 takes line 20", d0, 32'h0001_0014);
    chk("R11 cpu1 takes line 21", d1, 32'h0001_0015);
    bus_wr(16'h0180, 32'h0010_0000);
    ev_rd(2'b11, d0, d1);
    chk("R11 cpu0 wins shared line", d0, 32'h0001_0014);
    chk("R11 cpu1 gets no duplicate", d1, 32'h0);
    // acknowledge collides with mask clear
    bus_wr(16'h0180, 32'h0010_0000);
    @(negedge clk);
    ev_valid = 2'b01; b_valid = 1; b_we = 1; b_addr = 16'h0180; b_wdata = 32'h0010_0000;
    @(negedge clk);
    ev_valid = '0; b_valid = 0; b_we = 0;
    chk("R4 collision reports line 20", ev_rdata[31:0], 32'h0001_0014);
    bus_rd(16'h0100, d); chk("R4 acknowledge beats clear", d, 32'hFFFF_FFF7);
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R12 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule